// File: doc/BRIEF.md
# Code Memory Lock-Bit Protection Unit

This block keeps three lock bits for the on-chip code store of a small microcontroller and derives from them a cumulative protection level. Each request, whether from the fetch unit or from the parallel programmer, passes through the block and comes out as a grant only when the current level permits that kind of access. The bits act like non-volatile cells. They power up blank. A program strobe can only set them, and only a chip erase clears them. A system reset leaves them as they are.

Once the first lock bit is set, the level of the external-access pin is captured on every clock edge during reset and held after reset ends. The held value is reported, together with a flag that is raised while it differs from the live pin level. The capture register starts at a fixed value of 0, and a flag marks it as never loaded until the first capture.

Top module: `code_lock_unit`

## Requirements
- R1: At power-up, `lock_status` is 000. It always shows the three lock bits, with bit i being lock bit i+1, in every protection level.
- R2: A high `lock_prog[i]` at a clock edge sets bit i, and the bit is visible from the next cycle. A set bit stays set through resets and further strobes.
- R3: A high `chip_erase` at a clock edge clears all three bits. It takes priority over any program strobe in the same cycle.
- R4: `prot_level` equals the number of consecutively set bits counted from bit 0. The codes are 0 (none), 1 (bit 0), 2 (bits 0 and 1) and 3 (all three). A bit set above a clear bit adds nothing.
- R5: At level 0, every grant output equals its request input.
- R6: At level 1 or higher, `gnt_tbl_ext` and `gnt_code_prog` are 0.
- R7: At level 2 or higher, `gnt_code_verify` is 0. Below level 2 it follows its request.
- R8: At level 3, `gnt_ext_exec` is 0. Below level 3 it follows its request. `gnt_int_fetch` follows its request at every level.
- R9: `ea_held` loads `ea_pin` at each clock edge where `rst_n` is low and the level is at least 1. At all other edges it keeps its value.
- R10: `ea_unknown` is 1 and `ea_held` is 0 from power-up until the first load described in R9. After that load, `ea_unknown` is 0.
- R11: `ea_mismatch` is 1 exactly when the level is at least 1 and `ea_held` differs from `ea_pin`. It responds in the same cycle as the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; does not touch the lock bits |
| ea_pin | input | 1 | Live external-access pin level |
| lock_prog | input | 3 | Per-bit program strobes |
| chip_erase | input | 1 | Chip-erase strobe, clears all lock bits |
| req_tbl_ext | input | 1 | Table read of internal code issued from external code |
| req_int_fetch | input | 1 | Instruction fetch from internal code |
| req_code_prog | input | 1 | Programmer write to the code array |
| req_code_verify | input | 1 | Programmer verify read of the code array |
| req_ext_exec | input | 1 | Execution from external memory |
| gnt_tbl_ext | output | 1 | Grant for table read from external code |
| gnt_int_fetch | output | 1 | Grant for internal fetch |
| gnt_code_prog | output | 1 | Grant for code programming |
| gnt_code_verify | output | 1 | Grant for code verify |
| gnt_ext_exec | output | 1 | Grant for external execution |
| lock_status | output | 3 | Lock-bit readback |
| prot_level | output | 2 | Protection level 0..3 |
| ea_held | output | 1 | Captured external-access level |
| ea_unknown | output | 1 | Capture register never loaded since power-up |
| ea_mismatch | output | 1 | Captured and live pin levels differ while locked |

## Verification
The lock bits, the level and every grant that depends on a strobe change one rising edge after the strobe, because the grants decode the registered bits with no further register. `ea_held` and `ea_unknown` move one edge after a reset cycle in which the level was nonzero. `ea_mismatch` and the grants follow `ea_pin` and the requests in the same cycle. The bench drives all inputs just after a rising edge and updates its reference model on that same edge. It compares every output on the falling edge, so each result is sampled in the cycle where it is due.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int LOCK_N = 3;
  localparam int LVL_W  = $clog2(LOCK_N + 1);

  // Minimum level at which each access kind is refused
  localparam int DENY_TBL_LVL    = 1;
  localparam int DENY_PROG_LVL   = 1;
  localparam int DENY_VERIFY_LVL = 2;
  localparam int DENY_EXEC_LVL   = 3;

  typedef struct packed {
    logic tbl_ext;
    logic int_fetch;
    logic code_prog;
    logic code_verify;
    logic ext_exec;
  } access_t;

  // Count set bits from bit 0 upward, stopping at the first clear bit
  function automatic logic [LVL_W-1:0] run_level(input logic [LOCK_N-1:0] bits);
    int n;
    n = 0;
    for (int i = 0; i < LOCK_N; i++) begin
      if (bits[i] && (n == i)) n = i + 1;
    end
    return LVL_W'(n);
  endfunction

  function automatic logic below(input logic [LVL_W-1:0] lvl, input int limit);
    return (int'(lvl) < limit);
  endfunction

  function automatic access_t filter(input access_t req, input logic [LVL_W-1:0] lvl);
    access_t g;
    g.tbl_ext     = req.tbl_ext     & below(lvl, DENY_TBL_LVL);
    g.int_fetch   = req.int_fetch;
    g.code_prog   = req.code_prog   & below(lvl, DENY_PROG_LVL);
    g.code_verify = req.code_verify & below(lvl, DENY_VERIFY_LVL);
    g.ext_exec    = req.ext_exec    & below(lvl, DENY_EXEC_LVL);
    return g;
  endfunction

endpackage

// File: rtl/lock_bit_cell.sv
module lock_bit_cell (
  input  logic clk,
  input  logic set_stb,
  input  logic clr_stb,
  output logic bit_q
);
  // Blank state at power-up models an erased cell; reset leaves it alone
  logic cell_r = 1'b0;

  always_ff @(posedge clk) begin
    if (clr_stb)      cell_r <= 1'b0;
    else if (set_stb) cell_r <= 1'b1;
  end

  assign bit_q = cell_r;
endmodule

// File: rtl/lock_bit_bank.sv
module lock_bit_bank
  import lock_pkg::*;
(
  input  logic              clk,
  input  logic [LOCK_N-1:0] prog_stb,
  input  logic              erase_stb,
  output logic [LOCK_N-1:0] bits,
  output logic [LVL_W-1:0]  level
);
  genvar gi;
  generate
    for (gi = 0; gi < LOCK_N; gi++) begin : g_cell
      lock_bit_cell u_cell (
        .clk     (clk),
        .set_stb (prog_stb[gi]),
        .clr_stb (erase_stb),
        .bit_q   (bits[gi])
      );
    end
  endgenerate

  assign level = run_level(bits);
endmodule

// File: rtl/ea_sample_latch.sv
module ea_sample_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pin,
  output logic held,
  output logic unknown,
  output logic mismatch,
  output logic load_evt
);
  logic held_r    = 1'b0;
  logic unknown_r = 1'b1;

  assign load_evt = ~rst_n & armed;

  always_ff @(posedge clk) begin
    if (load_evt) begin
      held_r    <= pin;
      unknown_r <= 1'b0;
    end
  end

  assign held     = held_r;
  assign unknown  = unknown_r;
  assign mismatch = armed & (held_r ^ pin);
endmodule

// File: rtl/access_policy.sv
module access_policy
  import lock_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  access_t          req,
  output access_t          gnt
);
  assign gnt = filter(req, level);
endmodule

// File: rtl/code_lock_unit.sv
module code_lock_unit
  import lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ea_pin,
  input  logic [LOCK_N-1:0] lock_prog,
  input  logic              chip_erase,
  input  logic              req_tbl_ext,
  input  logic              req_int_fetch,
  input  logic              req_code_prog,
  input  logic              req_code_verify,
  input  logic              req_ext_exec,
  output logic              gnt_tbl_ext,
  output logic              gnt_int_fetch,
  output logic              gnt_code_prog,
  output logic              gnt_code_verify,
  output logic              gnt_ext_exec,
  output logic [LOCK_N-1:0] lock_status,
  output logic [LVL_W-1:0]  prot_level,
  output logic              ea_held,
  output logic              ea_unknown,
  output logic              ea_mismatch
);
  logic [LOCK_N-1:0] bits_w;
  logic [LVL_W-1:0]  level_w;
  logic              armed_w;
  logic              ea_load_w;
  access_t           req_w;
  access_t           gnt_w;

  lock_bit_bank u_bank (
    .clk       (clk),
    .prog_stb  (lock_prog),
    .erase_stb (chip_erase),
    .bits      (bits_w),
    .level     (level_w)
  );

  assign armed_w = (level_w != '0);

  ea_sample_latch u_ea (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed_w),
    .pin      (ea_pin),
    .held     (ea_held),
    .unknown  (ea_unknown),
    .mismatch (ea_mismatch),
    .load_evt (ea_load_w)
  );

  assign req_w = '{tbl_ext:     req_tbl_ext,
                   int_fetch:   req_int_fetch,
                   code_prog:   req_code_prog,
                   code_verify: req_code_verify,
                   ext_exec:    req_ext_exec};

  access_policy u_policy (
    .level (level_w),
    .req   (req_w),
    .gnt   (gnt_w)
  );

  assign gnt_tbl_ext     = gnt_w.tbl_ext;
  assign gnt_int_fetch   = gnt_w.int_fetch;
  assign gnt_code_prog   = gnt_w.code_prog;
  assign gnt_code_verify = gnt_w.code_verify;
  assign gnt_ext_exec    = gnt_w.ext_exec;
  assign lock_status     = bits_w;
  assign prot_level      = level_w;
endmodule

// File: rtl/lock_unit_checks.sv
module lock_unit_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       ea_pin,
  input logic [2:0] lock_prog,
  input logic       chip_erase,
  input logic       req_int_fetch,
  input logic       gnt_tbl_ext,
  input logic       gnt_int_fetch,
  input logic       gnt_code_prog,
  input logic       gnt_code_verify,
  input logic       gnt_ext_exec,
  input logic [2:0] lock_status,
  input logic [1:0] prot_level,
  input logic       ea_held,
  input logic       ea_unknown,
  input logic       ea_mismatch,
  input logic       ea_load_w
);
  AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase |=> (lock_status == 3'b000)); // R3

  AST_PROG_SETS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_prog[0] && !chip_erase) |=> lock_status[0]); // R2

  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_erase |=> ((lock_status & $past(lock_status)) == $past(lock_status))); // R2

  AST_LOCKED_NO_TBL_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    lock_status[0] |-> (!gnt_tbl_ext && !gnt_code_prog)); // R6

  AST_NO_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level >= 2'd2) |-> !gnt_code_verify); // R7

  AST_NO_EXT_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level == 2'd3) |-> !gnt_ext_exec); // R8

  AST_FETCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_int_fetch == req_int_fetch); // R8

  AST_EA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(ea_held)); // R9

  AST_EA_LOAD_NEEDS_LOCK: assert property (@(posedge clk)
    ea_load_w |-> (lock_status[0] && !rst_n)); // R9

  AST_KNOWN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_unknown |=> !ea_unknown); // R10

  AST_MISMATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ea_mismatch |-> ((prot_level != 2'd0) && (ea_held != ea_pin))); // R11
endmodule

bind code_lock_unit lock_unit_checks u_checks (
  .clk             (clk),
  .rst_n           (rst_n),
  .ea_pin          (ea_pin),
  .lock_prog       (lock_prog),
  .chip_erase      (chip_erase),
  .req_int_fetch   (req_int_fetch),
  .gnt_tbl_ext     (gnt_tbl_ext),
  .gnt_int_fetch   (gnt_int_fetch),
  .gnt_code_prog   (gnt_code_prog),
  .gnt_code_verify (gnt_code_verify),
  .gnt_ext_exec    (gnt_ext_exec),
  .lock_status     (lock_status),
  .prot_level      (prot_level),
  .ea_held         (ea_held),
  .ea_unknown      (ea_unknown),
  .ea_mismatch     (ea_mismatch),
  .ea_load_w       (ea_load_w)
);

// File: tb/code_lock_unit_test.sv
`timescale 1ns/1ps
module code_lock_unit_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       ea_pin = 1'b1;
  logic [2:0] lock_prog = 3'b000;
  logic       chip_erase = 1'b0;
  logic [4:0] req = 5'b0;
  logic       gnt_tbl_ext, gnt_int_fetch, gnt_code_prog, gnt_code_verify, gnt_ext_exec;
  logic [2:0] lock_status;
  logic [1:0] prot_level;
  logic       ea_held, ea_unknown, ea_mismatch;
  logic       req_on = 1'b0;

  code_lock_unit uut (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .lock_prog(lock_prog),
    .chip_erase(chip_erase),
    .req_tbl_ext(req[4]), .req_int_fetch(req[3]), .req_code_prog(req[2]),
    .req_code_verify(req[1]), .req_ext_exec(req[0]),
    .gnt_tbl_ext(gnt_tbl_ext), .gnt_int_fetch(gnt_int_fetch),
    .gnt_code_prog(gnt_code_prog), .gnt_code_verify(gnt_code_verify),
    .gnt_ext_exec(gnt_ext_exec), .lock_status(lock_status),
    .prot_level(prot_level), .ea_held(ea_held), .ea_unknown(ea_unknown),
    .ea_mismatch(ea_mismatch)
  );

  // Reference model state
  int  m_bit [3] = '{0, 0, 0};
  int  m_ea = 0;
  int  m_unk = 1;
  int  m_last = 0; // 0 none, 1 program, 2 erase at the previous edge
  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  function automatic int m_level();
    int k = 0;
    while (k < 3 && m_bit[k] != 0) k++;
    return k;
  endfunction

  always @(posedge clk) begin
    int lv;
    lv = m_level();
    if (!rst_n && lv > 0) begin
      m_ea  = ea_pin ? 1 : 0;
      m_unk = 0;
    end
    if (chip_erase) begin
      foreach (m_bit[k]) m_bit[k] = 0;
      m_last = 2;
    end else if (lock_prog != 3'b000) begin
      foreach (m_bit[k]) if (lock_prog[k]) m_bit[k] = 1;
      m_last = 1;
    end else m_last = 0;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int lv, st;
    string gt;
    if (!done) begin
      lv = m_level();
      st = m_bit[0] + 2 * m_bit[1] + 4 * m_bit[2];
      chk(m_last == 2 ? "R3" : (m_last == 1 ? "R2" : "R1"), "lock_status", lock_status, st);
      chk("R4", "prot_level", prot_level, lv);
      gt = (lv == 0) ? "R5" : "R6";
      chk(gt, "gnt_tbl_ext", gnt_tbl_ext, (lv == 0) ? req[4] : 0);
      chk(gt, "gnt_code_prog", gnt_code_prog, (lv == 0) ? req[2] : 0);
      chk((lv == 0) ? "R5" : "R7", "gnt_code_verify", gnt_code_verify, (lv >= 2) ? 0 : req[1]);
      chk((lv == 0) ? "R5" : "R8", "gnt_ext_exec", gnt_ext_exec, (lv == 3) ? 0 : req[0]);
      chk("R8", "gnt_int_fetch", gnt_int_fetch, req[3]);
      chk("R9", "ea_held", ea_held, m_ea);
      chk("R10", "ea_unknown", ea_unknown, m_unk);
      chk("R11", "ea_mismatch", ea_mismatch, (lv > 0 && m_ea != (ea_pin ? 1 : 0)) ? 1 : 0);
    end
  end

  // Request traffic on every cycle
  always @(posedge clk) begin
    #1;
    if (req_on) req <= 5'($urandom);
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_prog(input logic [2:0] m, input logic er);
    lock_prog = m; chip_erase = er;
    cycles(1);
    lock_prog = 3'b000; chip_erase = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    // R10: reset while unlocked does not load the capture register
    cycles(4);
    rst_n = 1'b1; req_on = 1'b1;
    cycles(20);
    // R4: bit 1 alone leaves the level at 0
    pulse_prog(3'b010, 1'b0);
    cycles(10);
    ea_pin = 1'b0; rst_n = 1'b0; cycles(3); rst_n = 1'b1;
    cycles(5);
    // R2 R6 R7: bit 0 completes level 2
    pulse_prog(3'b001, 1'b0);
    cycles(10);
    ea_pin = 1'b1; cycles(5); // R11 mismatch against initial capture value
    // R9: reset while locked captures the pin
    rst_n = 1'b0; cycles(3); rst_n = 1'b1;
    cycles(5);
    ea_pin = 1'b0; cycles(4); ea_pin = 1'b1; cycles(4);
    // R8: level 3
    pulse_prog(3'b100, 1'b0);
    cycles(20);
    pulse_prog(3'b001, 1'b0);
    cycles(5);
    // R3: erase wins over simultaneous programming
    pulse_prog(3'b111, 1'b1);
    cycles(10);
    // Mixed random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      lock_prog  = (r < 8) ? 3'($urandom) : 3'b000;
      chip_erase = (r >= 95);
      rst_n      = !(r >= 8 && r < 12);
      if (r >= 12 && r < 20) ea_pin = ~ea_pin;
      cycles(1);
    end
    lock_prog = 3'b000; chip_erase = 1'b0; rst_n = 1'b1;
    cycles(3);
    finish_run();
  end
endmodule